// File: doc/BRIEF.md
# Carry-Save Reduction Tree Multiplier

This block multiplies two unsigned N-bit operands and returns their full 2N-bit product with no clock and no state. It first forms N partial products: row i is the multiplicand gated by multiplier bit i and shifted left by i places. A layered carry-save network then reduces these rows to two vectors, and a parallel-prefix carry-lookahead adder adds them.

Each reduction layer splits its rows into groups of six. Each group goes through a six-to-three unit. That unit counts the six bits in every column and returns a three-bit count as three vectors, shifted by 0, 1 and 2 places. When three to five rows are left over, three of them go through a three-to-two full-adder row and the rest pass straight to the next layer. Fewer than three leftover rows pass unchanged. Every row count shrinks at each layer, so the number of layers grows with the logarithm of N. No carry travels along the word inside a layer, so each layer has a fixed depth whatever the operand width.

The block is meant to sit inside a larger datapath that registers its operands and its product. The interface is plain combinational data. No valid/ready handshake is used, because the product depends on nothing except the current operands and the block never stalls.

Top module: `csa_tree_mult`

## Requirements
- R1: For any operands, `p` equals the exact unsigned product of `a` and `b`, held in 2N bits with no bit dropped.
- R2: When either operand is zero, `p` is zero.
- R3: When one operand equals 1, `p` equals the other operand, zero-extended to 2N bits.
- R4: When both operands are all ones, `p` equals (2^N - 1)^2, so bit 0 is 1, bits N+1 to 2N-1 are 1, and bits 1 to N are 0.
- R5: When `a` has only bit k set, `p` equals `b` shifted left by k places, and the same holds with the roles of `a` and `b` swapped.
- R6: The final adder returns the exact 2N-bit sum of the two vectors that leave the reduction network, including carries that ripple across the whole word.
- R7: The two vectors that leave the reduction network add up, modulo 2^2N, to the sum of all N partial products.
- R8: The result is correct for N values whose row counts leave remainders that pass straight through a layer as well as remainders that need a three-to-two row.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| a | input | N | Multiplicand, unsigned |
| b | input | N | Multiplier, unsigned; bit i enables partial-product row i |
| p | output | 2N | Full unsigned product |

## Verification
The bench builds two copies of the block: one with N = 16 and one with N = 7. The N = 16 copy reduces 16 rows through five layers and uses both unit types, including a layer where a three-to-two row takes a remainder of three. The N = 7 copy leaves a single row that passes through a layer untouched, and it reaches a width where every random operand pair covers a good share of the whole input space. Both copies receive the same stimulus, truncated to their widths. Alternating bit patterns and all-ones operands force carries across the full width of the lookahead adder.

// File: rtl/csa_mult_pkg.sv
package csa_mult_pkg;

  // Rows left after one reduction layer that starts with n rows.
  function automatic int csa_next(input int n);
    int g6;
    int r;
    g6 = n / 6;
    r  = n % 6;
    if (r >= 3) return 3 * g6 + 2 + (r - 3);
    return 3 * g6 + r;
  endfunction

  // Rows present at the input of layer lvl.
  function automatic int csa_count(input int n, input int lvl);
    int c;
    c = n;
    for (int i = 0; i < lvl; i++) c = csa_next(c);
    return c;
  endfunction

  // Layers needed to bring n rows down to two.
  function automatic int csa_levels(input int n);
    int c;
    int k;
    c = n;
    k = 0;
    while (c > 2) begin
      c = csa_next(c);
      k++;
    end
    return k;
  endfunction

endpackage

// File: rtl/csa_fa.sv
module csa_fa (
  input  logic x,
  input  logic y,
  input  logic z,
  output logic s,
  output logic c
);
  assign s = x ^ y ^ z;
  assign c = (x & y) | (x & z) | (y & z);
endmodule

// File: rtl/csa_3to2.sv
module csa_3to2 #(
  parameter int W = 32
) (
  input  logic [2:0][W-1:0] x,
  output logic [W-1:0]      s,
  output logic [W-1:0]      c
);
  logic [W-1:0] cy;

  for (genvar i = 0; i < W; i++) begin : g_col
    csa_fa u_fa (.x(x[0][i]), .y(x[1][i]), .z(x[2][i]), .s(s[i]), .c(cy[i]));
  end

  assign c = {cy[W-2:0], 1'b0};
endmodule

// File: rtl/csa_6to3.sv
module csa_6to3 #(
  parameter int W = 32
) (
  input  logic [5:0][W-1:0] x,
  output logic [W-1:0]      o0,
  output logic [W-1:0]      o1,
  output logic [W-1:0]      o2
);
  logic [W-1:0] sa, ca, sb, cb, w1, w2;

  // Each column: count of six equal-weight bits, returned as a 3-bit number.
  for (genvar i = 0; i < W; i++) begin : g_col
    csa_fa u_lo (.x(x[0][i]), .y(x[1][i]), .z(x[2][i]), .s(sa[i]), .c(ca[i]));
    csa_fa u_hi (.x(x[3][i]), .y(x[4][i]), .z(x[5][i]), .s(sb[i]), .c(cb[i]));
    csa_fa u_mid (.x(ca[i]), .y(cb[i]), .z(sa[i] & sb[i]), .s(w1[i]), .c(w2[i]));
    assign o0[i] = sa[i] ^ sb[i];
  end

  assign o1 = {w1[W-2:0], 1'b0};
  assign o2 = {w2[W-3:0], 2'b00};
endmodule

// File: rtl/csa_cla.sv
module csa_cla #(
  parameter int W = 32
) (
  input  logic [W-1:0] x,
  input  logic [W-1:0] y,
  output logic [W-1:0] s
);
  localparam int LG = $clog2(W);

  logic [LG:0][W-1:0] gk;
  logic [LG:0][W-1:0] pk;

  assign gk[0] = x & y;
  assign pk[0] = x ^ y;

  for (genvar k = 0; k < LG; k++) begin : g_lvl
    localparam int D = 1 << k;
    for (genvar i = 0; i < W; i++) begin : g_bit
      if (i >= D) begin : g_mix
        assign gk[k+1][i] = gk[k][i] | (pk[k][i] & gk[k][i-D]);
        assign pk[k+1][i] = pk[k][i] & pk[k][i-D];
      end else begin : g_pass
        assign gk[k+1][i] = gk[k][i];
        assign pk[k+1][i] = pk[k][i];
      end
    end
  end

  assign s = pk[0] ^ {gk[LG][W-2:0], 1'b0};
endmodule

// File: rtl/csa_tree_mult.sv
module csa_tree_mult
  import csa_mult_pkg::*;
#(
  parameter int N = 16
) (
  input  logic [N-1:0]   a,
  input  logic [N-1:0]   b,
  output logic [2*N-1:0] p
);
  localparam int W    = 2 * N;
  localparam int LVLS = csa_levels(N);

  logic [LVLS:0][N-1:0][W-1:0] lv;
  logic [W-1:0] fin_s;
  logic [W-1:0] fin_c;

  // Partial-product rows.
  for (genvar i = 0; i < N; i++) begin : g_pp
    assign lv[0][i] = b[i] ? (W'(a) << i) : '0;
  end

  // Reduction layers.
  for (genvar l = 0; l < LVLS; l++) begin : g_layer
    localparam int CI = csa_count(N, l);
    localparam int CO = csa_next(CI);
    localparam int G6 = CI / 6;
    localparam int R  = CI % 6;

    for (genvar g = 0; g < G6; g++) begin : g_six
      csa_6to3 #(.W(W)) u_c6 (
        .x (lv[l][6*g+5 -: 6]),
        .o0(lv[l+1][3*g]),
        .o1(lv[l+1][3*g+1]),
        .o2(lv[l+1][3*g+2])
      );
    end

    if (R >= 3) begin : g_rem3
      csa_3to2 #(.W(W)) u_c3 (
        .x(lv[l][6*G6+2 -: 3]),
        .s(lv[l+1][3*G6]),
        .c(lv[l+1][3*G6+1])
      );
      for (genvar j = 0; j < R - 3; j++) begin : g_fwd
        assign lv[l+1][3*G6+2+j] = lv[l][6*G6+3+j];
      end
    end else begin : g_remp
      for (genvar j = 0; j < R; j++) begin : g_fwd
        assign lv[l+1][3*G6+j] = lv[l][6*G6+j];
      end
    end

    for (genvar j = CO; j < N; j++) begin : g_zero
      assign lv[l+1][j] = '0;
    end
  end

  assign fin_s = lv[LVLS][0];
  assign fin_c = lv[LVLS][1];

  csa_cla #(.W(W)) u_add (.x(fin_s), .y(fin_c), .s(p));
endmodule

// File: rtl/csa_mult_chk.sv
module csa_mult_chk #(
  parameter int N = 16
) (
  input logic [N-1:0]   a,
  input logic [N-1:0]   b,
  input logic [2*N-1:0] p,
  input logic [2*N-1:0] fin_s,
  input logic [2*N-1:0] fin_c
);
  logic [2*N-1:0] prod_ref;
  logic [2*N-1:0] tree_sum;

  assign prod_ref = (2*N)'(a) * (2*N)'(b);
  assign tree_sum = fin_s + fin_c;

  always_comb begin
    AST_PRODUCT_EXACT: assert (p == prod_ref) else $error("product mismatch"); // R1
    AST_ZERO_ANNIHILATES: assert (!((a == '0) || (b == '0)) || (p == '0)) else $error("zero operand"); // R2
    AST_ONE_IDENTITY: assert (!(b == N'(1)) || (p == (2*N)'(a))) else $error("unit operand"); // R3
    AST_FINAL_ADD_EXACT: assert (p == tree_sum) else $error("final adder"); // R6
    AST_TREE_SUM_HOLDS: assert (tree_sum == prod_ref) else $error("tree total"); // R7
  end
endmodule

bind csa_tree_mult csa_mult_chk #(.N(N)) u_chk (
  .a(a), .b(b), .p(p), .fin_s(fin_s), .fin_c(fin_c)
);

// File: tb/tb_csa_tree_mult.sv
`timescale 1ns/1ps
module tb_csa_tree_mult;
  logic clk = 1'b0;
  always #2.5 clk = ~clk;

  logic [15:0] a16, b16;
  logic [31:0] p16;
  logic [6:0]  a7, b7;
  logic [13:0] p7;

  int n_vec  = 0;
  int n_fail = 0;
  bit done   = 1'b0;

  csa_tree_mult #(.N(16)) dut     (.a(a16), .b(b16), .p(p16));
  csa_tree_mult #(.N(7))  dut_odd (.a(a7),  .b(b7),  .p(p7));

  function automatic logic [31:0] exp16(input logic [15:0] x, input logic [15:0] y);
    logic [31:0] acc = '0;
    for (int i = 0; i < 16; i++) if (y[i]) acc = acc + ({16'b0, x} << i);
    return acc;
  endfunction

  function automatic logic [13:0] exp7(input logic [6:0] x, input logic [6:0] y);
    logic [13:0] acc = '0;
    for (int i = 0; i < 7; i++) if (y[i]) acc = acc + ({7'b0, x} << i);
    return acc;
  endfunction

  task automatic apply(input logic [15:0] x, input logic [15:0] y, input string req);
    @(posedge clk);
    #1;
    a16 = x; b16 = y; a7 = x[6:0]; b7 = y[6:0];
    @(negedge clk);
    n_vec++;
    if (p16 !== exp16(x, y)) begin
      n_fail++;
      $display("FAIL %s N=16 a=%h b=%h got %h exp %h", req, x, y, p16, exp16(x, y));
    end
    n_vec++;
    if (p7 !== exp7(x[6:0], y[6:0])) begin
      n_fail++;
      $display("FAIL %s N=7 a=%h b=%h got %h exp %h", req, x[6:0], y[6:0], p7, exp7(x[6:0], y[6:0]));
    end
  endtask

  initial begin
    logic [15:0] ra, rb;
    int seed_probe;
    a16 = '0; b16 = '0; a7 = '0; b7 = '0;
    seed_probe = $urandom(32'h5eed_0123);
    // idle state with zero operands
    apply(16'h0000, 16'h0000, "R2 idle");
    apply(16'h0000, 16'hffff, "R2 a zero");
    apply(16'hbeef, 16'h0000, "R2 b zero");
    apply(16'h0001, 16'h9c3d, "R3 a one");
    apply(16'h7a55, 16'h0001, "R3 b one");
    apply(16'hffff, 16'hffff, "R4 all ones R6");
    apply(16'haaaa, 16'h5555, "R6 alternating");
    apply(16'h5555, 16'haaaa, "R7 alternating");
    apply(16'hffff, 16'h0001, "R3 ones by one");
    for (int k = 0; k < 16; k++) begin
      rb = 16'($urandom);
      apply(16'(1) << k, rb, "R5 a single bit");
      apply(rb, 16'(1) << k, "R5 b single bit");
    end
    for (int t = 0; t < 1500; t++) begin
      ra = 16'($urandom);
      rb = 16'($urandom);
      if (t % 7 == 3) ra = ra | 16'hff00;
      apply(ra, rb, "R1 R7 R8 random");
    end
    done = 1'b1;
    $display("  == %0d vectors applied, %0d miscompares ==", n_vec, n_fail);
    $finish;
  end

  initial begin
    #1000000;
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog R1 got hang exp finish");
      $display("  == %0d vectors applied, %0d miscompares ==", n_vec, n_fail);
      $finish;
    end
  end
endmodule